// File: doc/BRIEF.md
# Multi-Page Logical Access Sequencer

This block runs one logical-memory access of any byte length up to a fixed page budget. From the start address and length it derives how many 4 KB pages the access touches. It then asks an external table walker to translate each page, lowest page first. Every returned frame is checked against the installed memory size and kept in a small local buffer. Only when every page has translated cleanly does the block move to the transfer phase. There it issues one command per page, each giving a physical byte address and a byte count. The data movement itself is done by whoever consumes those commands.

Write accesses can be run with low-address protection enabled. In that case each page address is screened against the two protected low windows before it is sent to the walker. A check-only request stops after the translation phase, so software can probe an access without moving data. Every request ends with a one-cycle done pulse that carries a status and a fault code. The first fault seen ends the whole access, and no transfer command is issued.

Top module: `mpage_access_seq`

## Requirements
- R1: The page count is ((start mod 4096) + length − 1) / 4096 + 1. A length of zero, or a count above MAX_PAGES (8), ends the request at once with status 2 and code 0, and no walk is issued.
- R2: Walk requests go out one at a time in ascending order. Page i asks for (start + 4096·i) with the low 12 bits cleared. The request and its address stay steady until the walker responds.
- R3: A walker response with its fault flag set ends the access with status 1 and the walker's code. No further walk and no transfer follows.
- R4: For a write with protection enabled, a page address (start + 4096·i) in [0, 512) or in [4096, 4608) ends the access with status 1 and code 0x04 before that page is walked. Reads, and writes with protection disabled, are unaffected.
- R5: A returned frame number greater than or equal to the installed page count ends the access with status 1 and code 0x05.
- R6: With check-only set, a clean translation of all pages ends with status 0, and no transfer command is issued.
- R7: Transfers start only after all pages have translated. Chunk k uses frame k with the current in-page offset as its low 12 bits. Its length is the smaller of the bytes remaining and the bytes left in the page. The write flag follows the request.
- R8: A transfer command stays valid with a steady address and length until it is accepted.
- R9: Every accepted request gives exactly one done pulse: status 0 is success, 1 is fault, 2 is a length error. The code is 0 unless the status is fault. After reset, done, walk request and transfer valid are all low.
- R10: A start pulse while a request is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a request (taken only when idle) |
| addr_i | input | AW | Logical start address |
| len_i | input | LW | Byte length |
| write_i | input | 1 | Access is a write |
| check_only_i | input | 1 | Translate and check only, move no data |
| lowprot_en_i | input | 1 | Low-address protection enabled |
| mem_pages_i | input | AW-12 | Number of installed 4 KB frames |
| walk_req_o | output | 1 | Translation request, held until response |
| walk_vaddr_o | output | AW | Page-aligned logical address to translate |
| walk_rsp_i | input | 1 | Walker response strobe |
| walk_fault_i | input | 1 | Walker reports a translation fault |
| walk_code_i | input | 8 | Walker fault code |
| walk_ppn_i | input | AW-12 | Translated frame number |
| xfer_valid_o | output | 1 | Transfer command valid |
| xfer_ready_i | input | 1 | Transfer command accepted |
| xfer_addr_o | output | AW | Physical byte address of chunk |
| xfer_len_o | output | LW | Chunk byte count |
| xfer_write_o | output | 1 | Chunk direction (1 = write) |
| done_o | output | 1 | One-cycle completion pulse |
| status_o | output | 2 | 0 ok, 1 fault, 2 length error |
| code_o | output | 8 | Fault code when status is 1 |

## Verification
Two checks can land in the same cycle: the walker's response for the last page is judged against the installed memory limit, and the same response closes the translation phase. The bench provokes this by giving a two-page check-only request a frame map whose second frame sits either exactly one below the limit or exactly at it. It then expects a clean done or an addressing fault, with the matching walk count. A second overlap comes from a stray start pulse issued while translation is under way. That run must still yield a single done pulse with the first request's outcome.

// File: rtl/mpas_pkg.sv
package mpas_pkg;
  localparam int CODE_W = 8;

  typedef enum logic [1:0] {
    ST_OK     = 2'd0,
    ST_FAULT  = 2'd1,
    ST_LENERR = 2'd2
  } mpas_status_e;

  localparam logic [CODE_W-1:0] CODE_PROT = 8'h04;
  localparam logic [CODE_W-1:0] CODE_ADDR = 8'h05;

  typedef enum logic [2:0] {
    S_IDLE,
    S_CHECK,
    S_WAIT,
    S_XPREP,
    S_XSET,
    S_XWAIT
  } mpas_state_e;
endpackage

// File: rtl/mpas_page_span.sv
// Derives the index of the last page an access touches and rejects
// requests that are empty or exceed the page budget.
module mpas_page_span #(
  parameter int LW   = 16,
  parameter int PB   = 12,
  parameter int MAXP = 8,
  parameter int IW   = 3
) (
  input  logic [PB-1:0] off_i,
  input  logic [LW-1:0] len_i,
  output logic          reject_o,
  output logic [IW-1:0] last_o
);
  localparam int SW = LW + 1;
  localparam int QW = SW - PB;

  logic [SW-1:0] end_off;
  logic [QW-1:0] span_m1;

  always_comb begin
    end_off  = SW'(off_i) + SW'(len_i) - SW'(1);
    span_m1  = QW'(end_off >> PB);
    reject_o = (len_i == '0) || (span_m1 >= QW'(MAXP));
    last_o   = span_m1[IW-1:0];
  end
endmodule

// File: rtl/mpas_low_guard.sv
// Flags addresses inside the two protected low windows.
module mpas_low_guard #(
  parameter int AW  = 32,
  parameter int PB  = 12,
  parameter int WIN = 512
) (
  input  logic [AW-1:0] addr_i,
  output logic          hit_o
);
  localparam logic [AW-1:0] PAGE_A = AW'(1 << PB);
  localparam logic [AW-1:0] WIN_A  = AW'(WIN);

  always_comb begin
    hit_o = (addr_i < WIN_A) ||
            ((addr_i >= PAGE_A) && (addr_i < PAGE_A + WIN_A));
  end
endmodule

// File: rtl/mpas_chunk.sv
// Chunk length: the smaller of what remains and what is left in the page.
module mpas_chunk #(
  parameter int LW = 16,
  parameter int PB = 12
) (
  input  logic [PB-1:0] off_i,
  input  logic [LW-1:0] rem_i,
  output logic [LW-1:0] chunk_o
);
  logic [LW-1:0] left;

  always_comb begin
    left    = LW'(1 << PB) - LW'(off_i);
    chunk_o = (rem_i < left) ? rem_i : left;
  end
endmodule

// File: rtl/mpas_page_buf.sv
// Small frame store with a registered read port (block RAM friendly).
module mpas_page_buf #(
  parameter int DEPTH = 8,
  parameter int W     = 20,
  parameter int IW    = 3
) (
  input  logic          clk,
  input  logic          we_i,
  input  logic [IW-1:0] waddr_i,
  input  logic [W-1:0]  wdata_i,
  input  logic [IW-1:0] raddr_i,
  output logic [W-1:0]  rdata_o
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we_i) mem[waddr_i] <= wdata_i;
    rdata_o <= mem[raddr_i];
  end
endmodule

// File: rtl/mpage_access_seq.sv
module mpage_access_seq
  import mpas_pkg::*;
#(
  parameter int AW        = 32,
  parameter int LW        = 16,
  parameter int PB        = 12,
  parameter int MAX_PAGES = 8,
  parameter int LOW_WIN   = 512
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start_i,
  input  logic [AW-1:0]      addr_i,
  input  logic [LW-1:0]      len_i,
  input  logic               write_i,
  input  logic               check_only_i,
  input  logic               lowprot_en_i,
  input  logic [AW-PB-1:0]   mem_pages_i,
  output logic               walk_req_o,
  output logic [AW-1:0]      walk_vaddr_o,
  input  logic               walk_rsp_i,
  input  logic               walk_fault_i,
  input  logic [CODE_W-1:0]  walk_code_i,
  input  logic [AW-PB-1:0]   walk_ppn_i,
  output logic               xfer_valid_o,
  input  logic               xfer_ready_i,
  output logic [AW-1:0]      xfer_addr_o,
  output logic [LW-1:0]      xfer_len_o,
  output logic               xfer_write_o,
  output logic               done_o,
  output logic [1:0]         status_o,
  output logic [CODE_W-1:0]  code_o
);
  localparam int PPNW = AW - PB;
  localparam int IW   = (MAX_PAGES > 1) ? $clog2(MAX_PAGES) : 1;
  localparam int PAGE = 1 << PB;

  mpas_state_e      state;
  logic [IW-1:0]    idx, last;
  logic [AW-1:0]    cur, start_q;
  logic [LW-1:0]    rem;
  logic             wr_q, co_q, lp_q;

  logic             span_reject;
  logic [IW-1:0]    span_last;
  logic             low_hit;
  logic [LW-1:0]    chunk;
  logic             beyond;
  logic             buf_we;
  logic [PPNW-1:0]  buf_rdata;

  mpas_page_span #(.LW(LW), .PB(PB), .MAXP(MAX_PAGES), .IW(IW)) u_span (
    .off_i   (addr_i[PB-1:0]),
    .len_i   (len_i),
    .reject_o(span_reject),
    .last_o  (span_last)
  );

  mpas_low_guard #(.AW(AW), .PB(PB), .WIN(LOW_WIN)) u_guard (
    .addr_i(cur),
    .hit_o (low_hit)
  );

  mpas_chunk #(.LW(LW), .PB(PB)) u_chunk (
    .off_i  (cur[PB-1:0]),
    .rem_i  (rem),
    .chunk_o(chunk)
  );

  assign beyond = (walk_ppn_i >= mem_pages_i);
  assign buf_we = (state == S_WAIT) && walk_rsp_i && !walk_fault_i && !beyond;

  mpas_page_buf #(.DEPTH(MAX_PAGES), .W(PPNW), .IW(IW)) u_buf (
    .clk    (clk),
    .we_i   (buf_we),
    .waddr_i(idx),
    .wdata_i(walk_ppn_i),
    .raddr_i(idx),
    .rdata_o(buf_rdata)
  );

  assign xfer_write_o = wr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= S_IDLE;
      walk_req_o   <= 1'b0;
      walk_vaddr_o <= '0;
      xfer_valid_o <= 1'b0;
      xfer_addr_o  <= '0;
      xfer_len_o   <= '0;
      done_o       <= 1'b0;
      status_o     <= ST_OK;
      code_o       <= '0;
      idx          <= '0;
      last         <= '0;
      cur          <= '0;
      start_q      <= '0;
      rem          <= '0;
      wr_q         <= 1'b0;
      co_q         <= 1'b0;
      lp_q         <= 1'b0;
    end else begin
      done_o <= 1'b0;
      case (state)
        S_IDLE: begin
          if (start_i) begin
            if (span_reject) begin
              done_o   <= 1'b1;
              status_o <= ST_LENERR;
              code_o   <= '0;
            end else begin
              start_q <= addr_i;
              cur     <= addr_i;
              rem     <= len_i;
              last    <= span_last;
              idx     <= '0;
              wr_q    <= write_i;
              co_q    <= check_only_i;
              lp_q    <= lowprot_en_i;
              state   <= S_CHECK;
            end
          end
        end
        S_CHECK: begin
          if (wr_q && lp_q && low_hit) begin
            done_o   <= 1'b1;
            status_o <= ST_FAULT;
            code_o   <= CODE_PROT;
            state    <= S_IDLE;
          end else begin
            walk_req_o   <= 1'b1;
            walk_vaddr_o <= {cur[AW-1:PB], {PB{1'b0}}};
            state        <= S_WAIT;
          end
        end
        S_WAIT: begin
          if (walk_rsp_i) begin
            walk_req_o <= 1'b0;
            if (walk_fault_i) begin
              done_o   <= 1'b1;
              status_o <= ST_FAULT;
              code_o   <= walk_code_i;
              state    <= S_IDLE;
            end else if (beyond) begin
              done_o   <= 1'b1;
              status_o <= ST_FAULT;
              code_o   <= CODE_ADDR;
              state    <= S_IDLE;
            end else if (idx == last) begin
              if (co_q) begin
                done_o   <= 1'b1;
                status_o <= ST_OK;
                code_o   <= '0;
                state    <= S_IDLE;
              end else begin
                idx   <= '0;
                cur   <= start_q;
                state <= S_XPREP;
              end
            end else begin
              idx   <= idx + IW'(1);
              cur   <= cur + AW'(PAGE);
              state <= S_CHECK;
            end
          end
        end
        S_XPREP: state <= S_XSET;
        S_XSET: begin
          xfer_valid_o <= 1'b1;
          xfer_addr_o  <= {buf_rdata, cur[PB-1:0]};
          xfer_len_o   <= chunk;
          state        <= S_XWAIT;
        end
        S_XWAIT: begin
          if (xfer_ready_i) begin
            xfer_valid_o <= 1'b0;
            if (rem == xfer_len_o) begin
              done_o   <= 1'b1;
              status_o <= ST_OK;
              code_o   <= '0;
              state    <= S_IDLE;
            end else begin
              rem   <= rem - xfer_len_o;
              cur   <= cur + AW'(xfer_len_o);
              idx   <= idx + IW'(1);
              state <= S_XPREP;
            end
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  AST_WALK_HOLD: assert property (@(posedge clk) disable iff (rst)
    walk_req_o && !walk_rsp_i |=> walk_req_o && $stable(walk_vaddr_o)); // R2

  AST_ADDR_LIMIT: assert property (@(posedge clk) disable iff (rst)
    walk_req_o && walk_rsp_i && !walk_fault_i && (walk_ppn_i >= mem_pages_i)
    |=> done_o && (status_o == ST_FAULT) && (code_o == CODE_ADDR)); // R5

  AST_PHASE_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(walk_req_o && xfer_valid_o)); // R7

  AST_CHUNK_FITS: assert property (@(posedge clk) disable iff (rst)
    xfer_valid_o |-> (xfer_len_o != '0) &&
      ((LW+1)'(xfer_addr_o[PB-1:0]) + (LW+1)'(xfer_len_o) <= (LW+1)'(PAGE))); // R7

  AST_XFER_HOLD: assert property (@(posedge clk) disable iff (rst)
    xfer_valid_o && !xfer_ready_i |=> xfer_valid_o && $stable(xfer_addr_o)
      && $stable(xfer_len_o)); // R8

  AST_CODE_CLEAN: assert property (@(posedge clk) disable iff (rst)
    done_o && (status_o != ST_FAULT) |-> (code_o == '0)); // R9
endmodule

// File: tb/mpage_access_seq_bench.sv
`timescale 1ns/1ps
module mpage_access_seq_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0;
  logic [31:0] addr_i = '0;
  logic [15:0] len_i = '0;
  logic        write_i = 1'b0, check_only_i = 1'b0, lowprot_en_i = 1'b0;
  logic [19:0] mem_pages_i = '0;
  logic        walk_req_o;
  logic [31:0] walk_vaddr_o;
  logic        walk_rsp_i = 1'b0, walk_fault_i = 1'b0;
  logic [7:0]  walk_code_i = '0;
  logic [19:0] walk_ppn_i = '0;
  logic        xfer_valid_o, xfer_ready_i = 1'b0;
  logic [31:0] xfer_addr_o;
  logic [15:0] xfer_len_o;
  logic        xfer_write_o, done_o;
  logic [1:0]  status_o;
  logic [7:0]  code_o;

  always #2.5 clk = ~clk;

  mpage_access_seq u_mpage_access_seq (
    .clk, .rst, .start_i, .addr_i, .len_i, .write_i, .check_only_i,
    .lowprot_en_i, .mem_pages_i, .walk_req_o, .walk_vaddr_o, .walk_rsp_i,
    .walk_fault_i, .walk_code_i, .walk_ppn_i, .xfer_valid_o, .xfer_ready_i,
    .xfer_addr_o, .xfer_len_o, .xfer_write_o, .done_o, .status_o, .code_o
  );

  int n_cmp = 0, n_bad = 0;
  logic [31:0] q_walk[$];
  logic [31:0] q_xaddr[$];
  int          q_xlen[$];
  bit          exp_wr;
  int cfg_fidx = -1, cfg_fcode = 0, cfg_base = 0, cfg_lat = 1;
  int widx = 0, done_cnt = 0, got_status = 0, got_code = 0;
  bit seen = 0, beat = 0, pvalid = 0;
  int wcnt = 0, k = 0;
  logic [31:0] hold_a, e_a;
  int hold_l, e_l;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Walker and transfer-sink models plus per-clock comparison.
  initial begin
    forever begin
      @(negedge clk);
      if (!rst) begin
        if (walk_rsp_i) walk_rsp_i = 1'b0;
        else if (walk_req_o) begin
          if (!seen) begin
            seen = 1; wcnt = cfg_lat;
            if (q_walk.size() == 0) chk(0, "R3 unexpected walk", walk_vaddr_o, 0);
            else begin
              e_a = q_walk.pop_front();
              chk(walk_vaddr_o == e_a, "R2 walk address", walk_vaddr_o, e_a);
            end
          end
          if (wcnt == 0) begin
            walk_rsp_i   = 1'b1;
            walk_fault_i = (widx == cfg_fidx);
            walk_code_i  = 8'(cfg_fcode);
            walk_ppn_i   = 20'(cfg_base + widx * 3);
            widx++; seen = 0;
          end else wcnt--;
        end
        if (xfer_ready_i && pvalid) beat = 0;
        pvalid = xfer_valid_o;
        if (xfer_valid_o) begin
          if (!beat) begin
            beat = 1; hold_a = xfer_addr_o; hold_l = int'(xfer_len_o);
            if (q_xaddr.size() == 0) chk(0, "R6 unexpected transfer", xfer_addr_o, 0);
            else begin
              e_a = q_xaddr.pop_front(); e_l = q_xlen.pop_front();
              chk(xfer_addr_o == e_a, "R7 chunk address", xfer_addr_o, e_a);
              chk(int'(xfer_len_o) == e_l, "R7 chunk length", xfer_len_o, e_l);
              chk(xfer_write_o == exp_wr, "R7 chunk direction", xfer_write_o, exp_wr);
            end
          end else
            chk(xfer_addr_o == hold_a && int'(xfer_len_o) == hold_l,
                "R8 stalled command changed", xfer_addr_o, hold_a);
        end
        k++;
        xfer_ready_i = (k % 3) != 0;
        chk(!(walk_req_o && xfer_valid_o), "R7 walk during transfer", 1, 0);
        if (done_o) begin
          done_cnt++; got_status = int'(status_o); got_code = int'(code_o);
        end
      end
    end
  end

  task automatic run(input logic [31:0] a, input int len, input bit wr, input bit co,
                     input bit lp, input int fidx, input int fcode, input int base,
                     input int memp, input bit poke, input string tag);
    int npg, st, code, pi, t;
    int ppn[8];
    longint cur, rem, pa;
    q_walk.delete(); q_xaddr.delete(); q_xlen.delete();
    st = 0; code = 0; npg = 0;
    if (len == 0) st = 2;
    else begin
      npg = (int'(a % 4096) + len - 1) / 4096 + 1;
      if (npg > 8) st = 2;
    end
    if (st == 0)
      for (int i = 0; i < npg && st == 0; i++) begin
        pa = longint'(a) + longint'(i) * 4096;
        if (wr && lp && (pa < 512 || (pa >= 4096 && pa < 4608))) begin st = 1; code = 4; end
        else begin
          q_walk.push_back(32'(pa) & 32'hFFFF_F000);
          if (i == fidx) begin st = 1; code = fcode; end
          else begin
            ppn[i] = base + i * 3;
            if (ppn[i] >= memp) begin st = 1; code = 5; end
          end
        end
      end
    if (st == 0 && !co) begin
      cur = longint'(a); rem = longint'(len); pi = 0;
      while (rem > 0) begin
        longint left, c;
        left = 4096 - (cur % 4096);
        c = (rem < left) ? rem : left;
        q_xaddr.push_back((32'(ppn[pi]) << 12) | 32'(cur % 4096));
        q_xlen.push_back(int'(c));
        cur += c; rem -= c; pi++;
      end
    end
    exp_wr = wr; cfg_fidx = fidx; cfg_fcode = fcode; cfg_base = base;
    widx = 0; done_cnt = 0;
    @(negedge clk);
    addr_i = a; len_i = 16'(len); write_i = wr; check_only_i = co;
    lowprot_en_i = lp; mem_pages_i = 20'(memp); start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    if (poke) begin
      repeat (3) @(negedge clk);
      addr_i = '0; len_i = '0; write_i = 1'b0; start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
    end
    t = 0;
    while (done_cnt == 0 && t < 5000) begin @(negedge clk); t++; end
    repeat (4) @(negedge clk);
    chk(done_cnt == 1, {tag, " R9 done pulse count"}, done_cnt, 1);
    chk(got_status == st, {tag, " R9 status"}, got_status, st);
    chk(got_code == code, {tag, " R9 code"}, got_code, code);
    chk(q_walk.size() == 0, {tag, " R2 missing walks"}, q_walk.size(), 0);
    chk(q_xaddr.size() == 0, {tag, " R7 missing transfers"}, q_xaddr.size(), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog R9 no completion actual=0 expected=1");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    chk(done_o == 1'b0, "R9 reset done", done_o, 0);
    chk(walk_req_o == 1'b0, "R9 reset walk", walk_req_o, 0);
    chk(xfer_valid_o == 1'b0, "R9 reset xfer", xfer_valid_o, 0);
    rst = 1'b0;
    // single page read
    run(32'h1234_5678, 100, 0, 0, 0, -1, 0, 16'h100, 32'hFFFFF, 0, "R7");
    // unaligned write over four pages
    run(32'h0001_0FF0, 16'h2020, 1, 0, 1, -1, 0, 16'h200, 32'hFFFFF, 0, "R7");
    // exactly the page budget
    run(32'h0020_0000, 8 * 4096, 0, 0, 0, -1, 0, 16'h300, 32'hFFFFF, 0, "R1");
    // one page over budget, and zero length
    run(32'h0020_0001, 8 * 4096, 0, 0, 0, -1, 0, 16'h300, 32'hFFFFF, 0, "R1");
    run(32'h0020_0000, 0, 1, 0, 0, -1, 0, 16'h300, 32'hFFFFF, 0, "R1");
    // walker fault on third page
    run(32'h0030_0000, 5 * 4096, 0, 0, 0, 2, 8'h11, 16'h400, 32'hFFFFF, 0, "R3");
    // low-address protection
    run(32'h0000_0300, 64, 1, 0, 1, -1, 0, 16'h500, 32'hFFFFF, 0, "R4");
    run(32'h0000_1100, 64, 1, 0, 1, -1, 0, 16'h500, 32'hFFFFF, 0, "R4");
    run(32'h0000_1100, 64, 0, 0, 1, -1, 0, 16'h500, 32'hFFFFF, 0, "R4");
    run(32'h0000_01FF, 64, 1, 0, 0, -1, 0, 16'h500, 32'hFFFFF, 0, "R4");
    run(32'h0000_1200, 64, 1, 0, 1, -1, 0, 16'h500, 32'hFFFFF, 0, "R4");
    // memory limit on the last page, with check-only
    run(32'h0040_0800, 4096, 0, 1, 0, -1, 0, 16'h40, 16'h43, 0, "R5");
    run(32'h0040_0800, 4096, 0, 1, 0, -1, 0, 16'h40, 16'h44, 0, "R6");
    run(32'h0050_0000, 3 * 4096, 1, 1, 1, -1, 0, 16'h600, 32'hFFFFF, 0, "R6");
    // stray start while busy
    cfg_lat = 4;
    run(32'h0001_0FF0, 16'h2020, 1, 0, 0, -1, 0, 16'h700, 32'hFFFFF, 1, "R10");
    cfg_lat = 0;
    run(32'h00AB_CFFF, 2, 0, 0, 0, -1, 0, 16'h800, 32'hFFFFF, 0, "R7");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule